// File: doc/BRIEF.md
# Chopper polarity sequence controller

This block sets the chopper polarity of a multiplexed measurement front end, one multiplexer cycle at a time. It also inserts an optional alternate multiplexer cycle, for example a die temperature reading, between regular cycles when firmware asks for one. The front end reports the end of each multiplexer cycle and the end of each accumulation transfer as falling edges on two busy lines. The block turns these edges into the polarity and alternate-cycle flag for the cycle that starts next.

With an automatic code on the 2-bit mode input, regular cycles alternate polarity. An alternate cycle runs positive under an automatic code. A forced code pins the polarity of every alternate cycle. It also pins the polarity of the first regular cycle after each transfer event. Firmware can therefore swap the forced code on successive intervals, so that the front-end DC offset cancels out of the alternate-cycle readings.

The block counts regular cycles, but not alternate ones. It pulses an interval-end output when the last regular cycle of an accumulation interval completes.

Top module: `chop_seq_ctrl`

## Requirements
- R1: Under mode code 2'b00 or 2'b11 (automatic), each new regular cycle takes the complement of the polarity of the previous regular cycle. Polarity is encoded as pol_rev_o: 0 = positive, 1 = reversed.
- R2: Mode code 2'b10 forces positive polarity (pol_rev_o=0) and code 2'b01 forces reversed polarity (pol_rev_o=1). A forced code applies to every alternate cycle, and to the first regular cycle that starts on or after a falling edge of xfer_busy_i. Later regular cycles follow R1.
- R3: A high sample of alt_req_i sets a pending request. The next cycle boundary starts one alternate cycle (alt_cyc_o=1) and clears the request. Further requests while one is pending add no extra alternate cycle.
- R4: An alternate cycle under an automatic code runs positive. The regular cycle after it continues the R1 alternation from the last regular cycle.
- R5: intv_end_o pulses for one clock, together with cyc_end_o, when regular cycle number N_CYC of an interval ends. Alternate cycles are not counted.
- R6: After reset, the current cycle is regular with positive polarity, no request is pending, and cyc_end_o and intv_end_o are low.
- R7: A falling edge of cyc_busy_i, seen between two clock samples, raises cyc_end_o for exactly one clock at the next rising edge. pol_rev_o and alt_cyc_o update on that same edge and hold at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_busy_i | input | 1 | Multiplexer cycle busy; a falling edge ends a cycle |
| xfer_busy_i | input | 1 | Interval transfer busy; a falling edge marks a transfer done |
| alt_req_i | input | 1 | Firmware request for one alternate cycle |
| chop_mode_i | input | 2 | Polarity code: 10 positive, 01 reversed, 00/11 automatic |
| pol_rev_o | output | 1 | Polarity of the current cycle (1 = reversed) |
| alt_cyc_o | output | 1 | Current cycle is an alternate cycle |
| cyc_end_o | output | 1 | One-clock pulse at each cycle boundary |
| intv_end_o | output | 1 | One-clock pulse at each accumulation interval end |

## Verification
The bench builds the block with N_CYC=3. This short interval lets interval wrap-around happen several times inside each scenario. It also lets alternate cycles land both in the middle of an interval and directly after its last regular cycle, which shows that they are never counted. With the short interval, forced codes of both values can be checked across successive transfer events, and the return to automatic alternation can be seen a few cycles later.

// File: rtl/chop_seq_pkg.sv
package chop_seq_pkg;
  typedef enum logic [1:0] {
    MODE_AUTO_LO = 2'b00,
    MODE_REV     = 2'b01,
    MODE_POS     = 2'b10,
    MODE_AUTO_HI = 2'b11
  } chop_mode_e;

  function automatic logic mode_forced(input logic [1:0] m);
    return m[1] ^ m[0];
  endfunction

  function automatic logic mode_pol(input logic [1:0] m);
    return (chop_mode_e'(m) == MODE_REV);
  endfunction
endpackage

// File: rtl/chop_fall_det.sv
module chop_fall_det #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sig_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q[i] <= 1'b0;
      else         prev_q[i] <= sig_i[i];
    end
    assign fall_o[i] = prev_q[i] & ~sig_i[i];
  end
endmodule

// File: rtl/chop_req_latch.sv
module chop_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  // same-cycle set is visible to the consumer
  assign pend_o = pend_q | set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (take_i) pend_q <= 1'b0;
    else             pend_q <= pend_o;
  end
endmodule

// File: rtl/chop_pol_sel.sv
module chop_pol_sel
  import chop_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       alt_next_i,
  input  logic       first_i,
  input  logic [1:0] mode_i,
  output logic       pol_o,
  output logic       alt_o
);
  logic reg_pol_q, pol_q, alt_q;
  logic pol_d;

  always_comb begin
    if (alt_next_i)
      pol_d = mode_forced(mode_i) ? mode_pol(mode_i) : 1'b0;
    else if (first_i && mode_forced(mode_i))
      pol_d = mode_pol(mode_i);
    else
      pol_d = ~reg_pol_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q     <= 1'b0;
      alt_q     <= 1'b0;
      reg_pol_q <= 1'b0;
    end else if (step_i) begin
      pol_q <= pol_d;
      alt_q <= alt_next_i;
      if (!alt_next_i) reg_pol_q <= pol_d;
    end
  end

  assign pol_o = pol_q;
  assign alt_o = alt_q;

  // R1
  auto_flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !alt_next_i && !mode_forced(mode_i)) |=> (pol_o != $past(reg_pol_q)));
endmodule

// File: rtl/chop_intv_cnt.sv
module chop_intv_cnt #(
  parameter int unsigned N_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic wrap_o
);
  localparam int unsigned CNT_W = $clog2(N_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= step_i && (cnt_q == LAST);
      if (step_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign wrap_o = wrap_q;

  // R5
  wrap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |-> (cnt_q == '0));
endmodule

// File: rtl/chop_seq_ctrl.sv
module chop_seq_ctrl
  import chop_seq_pkg::*;
#(
  parameter int unsigned N_CYC = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cyc_busy_i,
  input  logic       xfer_busy_i,
  input  logic       alt_req_i,
  input  logic [1:0] chop_mode_i,
  output logic       pol_rev_o,
  output logic       alt_cyc_o,
  output logic       cyc_end_o,
  output logic       intv_end_o
);
  logic [1:0] fall;
  logic       bnd, xfer_fall, alt_next, first_pend, cyc_end_q;

  chop_fall_det #(.W(2)) u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sig_i ({xfer_busy_i, cyc_busy_i}),
    .fall_o(fall)
  );
  assign bnd       = fall[0];
  assign xfer_fall = fall[1];

  chop_req_latch u_alt_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (alt_req_i),
    .take_i(bnd),
    .pend_o(alt_next)
  );

  // consumed only by the next regular cycle
  chop_req_latch u_first_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (xfer_fall),
    .take_i(bnd && !alt_next),
    .pend_o(first_pend)
  );

  chop_pol_sel u_pol (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (bnd),
    .alt_next_i(alt_next),
    .first_i   (first_pend),
    .mode_i    (chop_mode_i),
    .pol_o     (pol_rev_o),
    .alt_o     (alt_cyc_o)
  );

  chop_intv_cnt #(.N_CYC(N_CYC)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(bnd && !alt_cyc_o),
    .wrap_o(intv_end_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_end_q <= 1'b0;
    else         cyc_end_q <= bnd;
  end
  assign cyc_end_o = cyc_end_q;

  // R7
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_end_o |-> ($stable(pol_rev_o) && $stable(alt_cyc_o)));

  // R5
  intv_on_regular_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    intv_end_o |-> (cyc_end_o && !$past(alt_cyc_o)));

  // R4
  alt_auto_pos_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_end_o && alt_cyc_o && !mode_forced($past(chop_mode_i))) |-> !pol_rev_o);

  // R2
  alt_forced_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_end_o && alt_cyc_o && mode_forced($past(chop_mode_i)))
      |-> (pol_rev_o == mode_pol($past(chop_mode_i))));
endmodule

// File: tb/chop_seq_ctrl_bench.sv
module chop_seq_ctrl_bench;
  localparam int unsigned N = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_busy = 1'b0, xfer_busy = 1'b0, alt_req = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       pol, alt, cend, iend;

  int checks = 0, fails = 0;

  // bench model, built from the requirements
  logic m_last = 1'b0, m_cur_alt = 1'b0, m_alt_pend = 1'b0, m_first = 1'b0;
  int   m_cnt = 0;

  always #2.5 clk = ~clk;

  chop_seq_ctrl #(.N_CYC(N)) u_chop_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cyc_busy_i(cyc_busy), .xfer_busy_i(xfer_busy),
    .alt_req_i(alt_req), .chop_mode_i(mode), .pol_rev_o(pol), .alt_cyc_o(alt),
    .cyc_end_o(cend), .intv_end_o(iend)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic logic forced(input logic [1:0] m);
    return (m == 2'b10) || (m == 2'b01);
  endfunction

  task automatic req_alt();
    @(negedge clk) alt_req = 1'b1;
    @(negedge clk) alt_req = 1'b0;
    m_alt_pend = 1'b1;
  endtask

  task automatic xfer_done();
    @(negedge clk) xfer_busy = 1'b1;
    @(negedge clk) xfer_busy = 1'b0;
    @(negedge clk);
    m_first = 1'b1;
  endtask

  task automatic end_cycle(input string tag);
    logic e_alt, e_pol, e_int;
    e_alt = m_alt_pend;
    if (e_alt) e_pol = (mode == 2'b01);
    else if (m_first && forced(mode)) e_pol = (mode == 2'b01);
    else e_pol = ~m_last;
    if (!e_alt) begin m_last = e_pol; m_first = 1'b0; end
    e_int = 1'b0;
    if (!m_cur_alt) begin
      if (m_cnt == N - 1) begin e_int = 1'b1; m_cnt = 0; end
      else m_cnt++;
    end
    m_cur_alt  = e_alt;
    m_alt_pend = 1'b0;
    @(negedge clk) cyc_busy = 1'b1;
    @(negedge clk) cyc_busy = 1'b0;
    @(negedge clk);
    chk({tag, " R7 cyc_end"}, cend, 1'b1);
    chk({tag, " R3 alt_cyc"}, alt, e_alt);
    chk({tag, " R1/R2/R4 pol"}, pol, e_pol);
    chk({tag, " R5 intv_end"}, iend, e_int);
    @(negedge clk);
    chk({tag, " R7 pulse width"}, cend, 1'b0);
    chk({tag, " R5 intv width"}, iend, 1'b0);
    chk({tag, " R7 pol hold"}, pol, e_pol);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R6 pol", pol, 1'b0);
    chk("R6 alt", alt, 1'b0);
    chk("R6 cyc_end", cend, 1'b0);
    chk("R6 intv_end", iend, 1'b0);
  endtask

  task automatic t_auto();
    mode = 2'b00;
    for (int i = 0; i < 4; i++) end_cycle("auto00 R1");
    mode = 2'b11;
    for (int i = 0; i < 3; i++) end_cycle("auto11 R1");
  endtask

  task automatic t_alt_auto();
    mode = 2'b00;
    req_alt();
    end_cycle("alt auto R4");
    end_cycle("after alt R4");
    req_alt();
    req_alt();
    end_cycle("double req R3");
    end_cycle("no second alt R3");
    for (int i = 0; i < 3; i++) end_cycle("count R5");
  endtask

  task automatic t_forced();
    mode = 2'b10;
    end_cycle("forced no xfer R2");
    xfer_done();
    end_cycle("forced pos R2");
    end_cycle("flip after forced R2");
    mode = 2'b01;
    xfer_done();
    end_cycle("forced rev R2");
    end_cycle("flip after rev R2");
    req_alt();
    end_cycle("alt forced rev R2");
    mode = 2'b10;
    req_alt();
    end_cycle("alt forced pos R2");
    xfer_done();
    req_alt();
    end_cycle("alt before first R2");
    end_cycle("first after alt R2");
    mode = 2'b00;
    end_cycle("back to auto R1");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_auto();
    t_alt_auto();
    t_forced();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule